// File: doc/BRIEF.md
# Microcoded Control Sequencer with Opcode Dispatch

This block is the control unit and datapath of a small 8-bit processor core. Every datapath control signal comes from a word of an internal microprogram table, not from decode logic on the instruction. A micro-program counter addresses that table. Each word sets the operand sources, an optional literal path, the ALU operation, the register write target, the two flag write enables and the next micro-address.

Some instruction bits skip the microprogram and go straight to the datapath: the destination, first-source and second-source register numbers, and a 4-bit literal that is sign-extended. The opcode bits only choose which microprogram runs. The all-ones micro-address is reserved as the "execute" code. When a word names it as its successor, the sequencer does four things in the same cycle: it takes a new instruction from the instruction port, looks up that instruction's entry address in an opcode table, sends that address to the micro-PC, and advances the instruction pointer. The instruction pointer never moves during the inner steps of a multi-step instruction.

The surrounding system presents, on `instr_i`, the instruction word at address `ip_o`. It can watch the register write-back on the `wb_*` ports.

Top module: `useq_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the instruction pointer, both flags and all sixteen registers, and points the micro-PC at the execute vector. In the first cycle after reset, `disp_o` is 1 and `wb_en_o` is 0.
- R2: Instruction format: bits [15:12] are the opcode, [11:8] the destination register, [7:4] source A and [3:0] source B or the literal. Opcodes: 0 = no-op, 1 = ADD, 2 = ADD-literal, 3 = SUB, 4 = AND, 5 = SWAP. `disp_o` is high in the last micro-step of each instruction.
- R3: ADD writes (A+B) mod 256 to the destination. Carry is set to bit 8 of the sum. Zero is set when the written value is 0.
- R4: ADD-literal sign-extends bits [3:0] to 8 bits and adds them to register A. Flags are set as for ADD.
- R5: SUB writes (A-B) mod 256. Carry is set to 1 exactly when A < B (a borrow). Zero is set as for ADD.
- R6: AND writes A&B and updates only the zero flag. The carry flag keeps its value.
- R7: SWAP takes two cycles. The first writes old B into register A, keeping old A in a temporary, with `disp_o` = 0. The second writes the temporary into register B, with `disp_o` = 1. No flag changes.
- R8: `ip_o` increases by one (mod 256) after each cycle with `disp_o` = 1 and holds after any cycle with `disp_o` = 0.
- R9: Opcodes 0 and 6 to 15 take one cycle. They write no register and leave both flags unchanged.
- R10: The instruction present on `instr_i` during a dispatch cycle controls the next cycle's register fields and microprogram, so `wb_idx_o` in that cycle comes from the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 16 | Instruction word at address `ip_o` |
| ip_o | output | 8 | Instruction pointer (fetch address) |
| disp_o | output | 1 | This cycle dispatches the next instruction |
| wb_en_o | output | 1 | Register write in this cycle |
| wb_idx_o | output | 4 | Register written |
| wb_data_o | output | 8 | Value written |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |

## Verification
A corrupted micro-PC or a wrong opcode table entry shows up in the same cycle. `disp_o` and the write-back ports disagree with the expected step of the current instruction, and `ip_o` drifts one cycle later. A wrong register or temporary value stays hidden until an instruction reads it. The program therefore reads back every written register, including both swapped registers, within a few instructions. Flag faults show at `z_o`/`c_o` in the cycle after the writing step. AND following a carry-setting operation exposes a carry flag that changes when it should not.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int OPC_W   = 4;
    localparam int RIX_W   = 4;
    localparam int REG_N   = 1 << RIX_W;
    localparam int INSTR_W = OPC_W + 3 * RIX_W;
    localparam int UADDR_W = 6;

    // reserved successor code: intercepted and replaced by the opcode entry
    localparam logic [UADDR_W-1:0] UA_EXEC = '1;

    localparam logic [OPC_W-1:0] OPC_NOP  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_ADD  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_ADDL = 4'd2;
    localparam logic [OPC_W-1:0] OPC_SUB  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_AND  = 4'd4;
    localparam logic [OPC_W-1:0] OPC_SWAP = 4'd5;

    typedef enum logic [2:0] {
        ALU_PASSA, ALU_PASSB, ALU_ADD, ALU_SUB, ALU_AND
    } alu_op_e;

    typedef enum logic [1:0] {
        WR_NONE, WR_DST, WR_SRCA, WR_SRCB
    } wr_sel_e;

    typedef struct packed {
        logic               a_tmp;   // A bus from temporary instead of register
        logic               b_zero;  // B bus forced to zero
        logic               c_lit;   // second ALU operand from literal C bus
        alu_op_e            alu;
        wr_sel_e            wr;
        logic               tmp_we;  // temporary captures the A bus
        logic               zf_we;
        logic               cf_we;
        logic [UADDR_W-1:0] next;
    } uword_t;

    localparam uword_t UW_SAFE = '{
        a_tmp: 1'b0, b_zero: 1'b0, c_lit: 1'b0, alu: ALU_PASSA, wr: WR_NONE,
        tmp_we: 1'b0, zf_we: 1'b0, cf_we: 1'b0, next: UA_EXEC
    };
endpackage

// File: rtl/useq_urom.sv
module useq_urom
    import useq_pkg::*;
(
    input  logic [UADDR_W-1:0] addr,
    output uword_t             word
);
    always_comb begin
        word = UW_SAFE;
        case (addr)
            6'd1: begin   // ADD
                word.alu = ALU_ADD; word.wr = WR_DST;
                word.zf_we = 1'b1; word.cf_we = 1'b1;
            end
            6'd2: begin   // ADD literal
                word.c_lit = 1'b1; word.alu = ALU_ADD; word.wr = WR_DST;
                word.zf_we = 1'b1; word.cf_we = 1'b1;
            end
            6'd3: begin   // SUB
                word.alu = ALU_SUB; word.wr = WR_DST;
                word.zf_we = 1'b1; word.cf_we = 1'b1;
            end
            6'd4: begin   // AND, zero flag only
                word.alu = ALU_AND; word.wr = WR_DST; word.zf_we = 1'b1;
            end
            6'd5: begin   // SWAP step 1
                word.tmp_we = 1'b1; word.alu = ALU_PASSB; word.wr = WR_SRCA;
                word.next = 6'd6;
            end
            6'd6: begin   // SWAP step 2
                word.a_tmp = 1'b1; word.alu = ALU_PASSA; word.wr = WR_SRCB;
            end
            default: word = UW_SAFE;
        endcase
    end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
(
    input  logic [OPC_W-1:0]   opc,
    output logic [UADDR_W-1:0] entry
);
    always_comb begin
        case (opc)
            OPC_ADD:  entry = 6'd1;
            OPC_ADDL: entry = 6'd2;
            OPC_SUB:  entry = 6'd3;
            OPC_AND:  entry = 6'd4;
            OPC_SWAP: entry = 6'd5;
            default:  entry = UA_EXEC;   // no-op: safe word, dispatches again
        endcase
    end
endmodule

// File: rtl/useq_alu.sv
module useq_alu
    import useq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    logic [DATA_W:0] wide;

    always_comb begin
        case (op)
            ALU_ADD:   wide = {1'b0, a} + {1'b0, b};
            ALU_SUB:   wide = {1'b0, a} - {1'b0, b};
            ALU_AND:   wide = {1'b0, a & b};
            ALU_PASSB: wide = {1'b0, b};
            default:   wide = {1'b0, a};
        endcase
        res  = wide[DATA_W-1:0];
        cout = wide[DATA_W];
    end
endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IP_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [INSTR_W-1:0]  instr_i,
    output logic [IP_W-1:0]     ip_o,
    output logic                disp_o,
    output logic                wb_en_o,
    output logic [RIX_W-1:0]    wb_idx_o,
    output logic [DATA_W-1:0]   wb_data_o,
    output logic                z_o,
    output logic                c_o
);
    localparam int OPR_W = INSTR_W - OPC_W;

    typedef struct packed {
        logic [UADDR_W-1:0]            upc;
        logic [OPR_W-1:0]              opr;
        logic [IP_W-1:0]               ip;
        logic                          zf;
        logic                          cf;
        logic [DATA_W-1:0]             tmp;
        logic [REG_N-1:0][DATA_W-1:0]  rf;
    } state_t;

    state_t s_d, s_q;
    uword_t uw;
    logic [UADDR_W-1:0] entry;
    logic [RIX_W-1:0]   f_dst, f_a, f_b, widx;
    logic [DATA_W-1:0]  abus, bbus, cbus, opb, res;
    logic               cout, wen, exec;

    useq_urom u_rom (.addr(s_q.upc), .word(uw));
    useq_dispatch u_disp (.opc(instr_i[INSTR_W-1 -: OPC_W]), .entry(entry));

    // register fields bypass the microprogram
    assign f_dst = s_q.opr[3*RIX_W-1 -: RIX_W];
    assign f_a   = s_q.opr[2*RIX_W-1 -: RIX_W];
    assign f_b   = s_q.opr[RIX_W-1:0];

    assign abus = uw.a_tmp  ? s_q.tmp : s_q.rf[f_a];
    assign bbus = uw.b_zero ? '0      : s_q.rf[f_b];
    assign cbus = {{(DATA_W-RIX_W){f_b[RIX_W-1]}}, f_b};
    assign opb  = uw.c_lit  ? cbus    : bbus;

    useq_alu #(.DATA_W(DATA_W)) u_alu (
        .a(abus), .b(opb), .op(uw.alu), .res(res), .cout(cout)
    );

    always_comb begin
        case (uw.wr)
            WR_DST:  widx = f_dst;
            WR_SRCA: widx = f_a;
            WR_SRCB: widx = f_b;
            default: widx = f_dst;
        endcase
        wen  = (uw.wr != WR_NONE);
        exec = (uw.next == UA_EXEC);
    end

    always_comb begin
        s_d = s_q;
        if (wen)       s_d.rf[widx] = res;
        if (uw.tmp_we) s_d.tmp      = abus;
        if (uw.zf_we)  s_d.zf       = (res == '0);
        if (uw.cf_we)  s_d.cf       = cout;
        if (exec) begin
            s_d.upc = entry;
            s_d.opr = instr_i[OPR_W-1:0];
            s_d.ip  = s_q.ip + 1'b1;
        end else begin
            s_d.upc = uw.next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q     <= '0;
            s_q.upc <= UA_EXEC;
        end else begin
            s_q <= s_d;
        end
    end

    assign ip_o      = s_q.ip;
    assign disp_o    = exec;
    assign wb_en_o   = wen;
    assign wb_idx_o  = widx;
    assign wb_data_o = res;
    assign z_o       = s_q.zf;
    assign c_o       = s_q.cf;
endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk #(
    parameter int IP_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            disp,
    input logic [IP_W-1:0] ip,
    input logic            zf,
    input logic            cf,
    input logic            zf_we,
    input logic            cf_we
);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> (ip == '0 && !zf && !cf && disp));

    // R8
    ip_step_chk: assert property (@(posedge clk) disable iff (rst)
        disp |=> ip == $past(ip) + 1'b1);

    // R8
    ip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !disp |=> $stable(ip));

    // R7
    swap_len_chk: assert property (@(posedge clk) disable iff (rst)
        !disp |=> disp);

    // R6
    carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !cf_we |=> $stable(cf));

    // R9
    zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !zf_we |=> $stable(zf));
endmodule

bind useq_core useq_core_chk #(.IP_W(IP_W)) u_chk (
    .clk(clk), .rst(rst), .disp(disp_o), .ip(ip_o), .zf(z_o), .cf(c_o),
    .zf_we(uw.zf_we), .cf_we(uw.cf_we)
);

// File: tb/tb_useq_core.sv
module tb_useq_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr;
    logic [7:0]  ip_o;
    logic        disp_o, wb_en_o, z_o, c_o;
    logic [3:0]  wb_idx_o;
    logic [7:0]  wb_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;   // 125 MHz

    useq_core dut (
        .clk(clk), .rst(rst), .instr_i(instr), .ip_o(ip_o), .disp_o(disp_o),
        .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o),
        .z_o(z_o), .c_o(c_o)
    );

    function automatic logic [15:0] prog(input int a);
        case (a)
            0:  return 16'h2105;  // r1 = r0 + 5            (R4)
            1:  return 16'h220D;  // r2 = r0 + (-3)         (R4)
            2:  return 16'h1312;  // r3 = r1 + r2, carry    (R3)
            3:  return 16'h3411;  // r4 = r1 - r1, zero     (R5)
            4:  return 16'h3512;  // r5 = r1 - r2, borrow   (R5)
            5:  return 16'h4621;  // r6 = r2 & r1           (R6)
            6:  return 16'h4710;  // r7 = r1 & r0, carry kept (R6)
            7:  return 16'h5012;  // swap r1, r2            (R7)
            8:  return 16'h9123;  // unused opcode          (R9)
            9:  return 16'h1810;  // r8 = r1 + r0
            10: return 16'h2927;  // r9 = r2 + 7
            11: return 16'h2A00;  // r10 = 0
            12: return 16'h5033;  // swap r3 with itself
            13: return 16'h1B30;  // r11 = r3
            14: return 16'h2C28;  // r12 = r2 + (-8)
            15: return 16'h2DC3;  // r13 = r12 + 3, wraps
            16: return 16'hF000;  // unused opcode          (R9)
            17: return 16'h3E21;  // r14 = r2 - r1
            18: return 16'h5001;  // swap r0, r1
            19: return 16'h1F01;  // r15 = r0 + r1
            default: return 16'h0000;
        endcase
    endfunction

    assign instr = prog(int'(ip_o));

    int m_rf[16];
    int m_ip, m_z, m_c, m_tmp, m_step, m_instr;
    bit m_fetch;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_rf[i] = 0;
        m_ip = 0; m_z = 0; m_c = 0; m_tmp = 0; m_step = 0; m_instr = 0;
        m_fetch = 1;
    endtask

    task automatic cycle();
        int op, d, a, b, lit, res, widx, wdat, nz, nc;
        bit we, dp;
        string tg;
        op = m_fetch ? 0 : (m_instr >> 12) & 15;
        d = (m_instr >> 8) & 15; a = (m_instr >> 4) & 15; b = m_instr & 15;
        lit = (b >= 8) ? b + 240 : b;
        we = 0; dp = 1; nz = m_z; nc = m_c; widx = 0; wdat = 0;
        tg = m_fetch ? "R1" : "R9";
        case (op)
            1: begin res = m_rf[a] + m_rf[b]; we = 1; widx = d; wdat = res & 255;
                     nz = (wdat == 0); nc = res >> 8; tg = "R3"; end
            2: begin res = m_rf[a] + lit; we = 1; widx = d; wdat = res & 255;
                     nz = (wdat == 0); nc = res >> 8; tg = "R4"; end
            3: begin we = 1; widx = d; wdat = (m_rf[a] - m_rf[b]) & 255;
                     nz = (wdat == 0); nc = (m_rf[a] < m_rf[b]); tg = "R5"; end
            4: begin we = 1; widx = d; wdat = m_rf[a] & m_rf[b];
                     nz = (wdat == 0); tg = "R6"; end
            5: begin
                tg = "R7"; we = 1;
                if (m_step == 0) begin widx = a; wdat = m_rf[b]; dp = 0; end
                else begin widx = b; wdat = m_tmp; end
            end
            default: ;
        endcase
        chk("R2", "disp", disp_o, dp);
        chk("R8", "ip", ip_o, m_ip);
        chk(tg, "wb_en", wb_en_o, we);
        if (we) begin
            chk("R10", "wb_idx", wb_idx_o, widx);
            chk(tg, "wb_data", wb_data_o, wdat);
        end
        chk(tg, "zero", z_o, m_z);
        chk(tg, "carry", c_o, m_c);
        if (op == 5 && m_step == 0) m_tmp = m_rf[a];
        if (we) m_rf[widx] = wdat;
        m_z = nz; m_c = nc;
        if (dp) begin
            m_instr = prog(m_ip); m_ip = (m_ip + 1) & 255;
            m_fetch = 0; m_step = 0;
        end else begin
            m_step = 1;
        end
    endtask

    task automatic reset_and_check();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        chk("R1", "ip after reset", ip_o, 0);
        chk("R1", "zero after reset", z_o, 0);
        chk("R1", "carry after reset", c_o, 0);
        chk("R1", "dispatch after reset", disp_o, 1);
        chk("R1", "no write after reset", wb_en_o, 0);
    endtask

    initial begin
        reset_and_check();
        for (int k = 0; k < 30; k++) begin
            cycle();
            @(negedge clk);
            #1;
        end
        // reset in mid-run, then run the program again
        reset_and_check();
        for (int k = 0; k < 40; k++) begin
            cycle();
            @(negedge clk);
            #1;
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule